// File: doc/BRIEF.md
# Four-Port Line Request Detector and Handler Dispatcher

This block sits at the front of a four-port mesh node. Each port has its own detector, which watches a bit-aligned line sample. A short alternating preamble brings a detector out of idle and raises a wake request for the node's clock control. The detector then reads a 4-bit request code and sorts the request into one of three kinds: a packet transfer between neighbours, a circuit-switched transfer toward the base, or a timing request.

A shared dispatcher assigns each classified request to the handler for its kind. Handler 0 is the packet receiver, handler 1 is the circuit-switch unit and handler 2 is the time-sync unit. Each handler serves one port at a time. When several ports want the same free handler in the same cycle, a rotating pointer for that handler chooses one port, and the other ports drop back to idle. The sending nodes must request again.

A granted port holds its request until its handler's busy flag falls. That falling edge produces a one-cycle release pulse that returns only the served port to idle. While a line is marked occupied by local traffic, its detector ignores it.

Top module: `line_req_dispatch`

## Requirements
- R1: After reset, `wake` is 0, `handlerEn` is 0 and every 2-bit field of `reqType` is 0 (no request).
- R2: A line idles low. A preamble is two line transitions in consecutive cycles. A single transition followed by a steady line never raises `wake`. `wake` is 1 in the cycle right after the edge that samples the second transition.
- R3: The 4 bits that follow the preamble are read most significant bit first. Code 1010 gives `reqType` 1 (handler 0), code 1100 gives 2 (handler 1) and code 1001 gives 3 (handler 2). The port's field shows this value in the cycle after the last code bit is sampled. Any other code returns the port to idle with field 0.
- R4: `wake` is 1 whenever any port has passed its preamble, which includes the whole time a request is waiting or being served. It is 0 once every port is idle.
- R5: While `lineBusy` of a port is 1, that port's line activity is ignored. A frame sent entirely under it gives no wake and no request, and asserting it part-way through a frame abandons the frame.
- R6: A request for a handler that is not owned and whose busy flag is 0 is granted at the next edge. The handler's `handlerEn` bit rises and its 2-bit `portSel` field (handler h at bits 2h+1:2h) names the port. Different handlers are granted to different ports in the same cycle.
- R7: While a handler's busy flag is 1 and no port owns it, requests for it wait with `reqType` held. The grant follows at the edge that samples the flag low.
- R8: Each handler keeps a pointer that starts at port 0. Among the ports requesting together, the winner is the first one found counting upward from the pointer, modulo 4. The pointer advances by one after every grant, and the losing ports return to field 0 at the grant edge.
- R9: A granted port keeps its `reqType` and its handler keeps `handlerEn` until the handler's busy flag falls. At the edge that samples the flag low after high, both clear, and only for the port that handler served.
- R10: While a port is being served, frames on its line have no effect on its request or on any handler.
- R11: `portSel` of a handler stays constant for as long as its `handlerEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; line samples arrive one bit per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| lineIn | input | 4 | Recovered line bit per port |
| lineBusy | input | 4 | Per-port flag: line occupied by local transmit or time sync |
| handlerBusy | input | 3 | Busy flag of packet receiver, circuit-switch unit, time-sync unit |
| wake | output | 1 | Wake request to the clock controller |
| reqType | output | 8 | Per-port request kind, 2 bits per port (0 none, 1 packet, 2 circuit, 3 timing) |
| handlerEn | output | 3 | Per-handler enable, high while the handler owns a port |
| portSel | output | 6 | Per-handler selected port, 2 bits per handler |

## Verification
The bench builds the block with its default parameters: a 4-bit code, a two-transition preamble and the three codes listed above. With a 4-bit code it is practical to send all 16 codes on every one of the four ports, so each valid and invalid classification is checked on each port. A separate case drives all four ports at once for the packet receiver, repeated over several rounds, to follow the pointer through its rotation. Other directed cases cover a lone transition, a frame aborted by the occupied flag, a grant deferred by a busy handler, and a frame sent while the port is being served.

// File: rtl/line_req_pkg.sv
package line_req_pkg;

  localparam int PORTS    = 4;
  localparam int HANDLERS = 3;
  localparam int PSEL_W   = $clog2(PORTS);
  localparam int TYPE_W   = 2;

  // request kind; handler index h serves kind h+1
  localparam logic [TYPE_W-1:0] KIND_NONE = 2'd0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CODE,
    ST_WAIT,
    ST_ACTIVE
  } portState_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic [PORTS-1:0]    edgeClr;
    logic [PORTS-1:0]    edgeInc;
    logic [PORTS-1:0]    codeClr;
    logic [PORTS-1:0]    codeShift;
    logic [HANDLERS-1:0] ptrStep;
  } dpStrobe_t;

endpackage

// File: rtl/line_req_datapath.sv
module line_req_datapath
  import line_req_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int PRE_EDGES = 2,
  localparam int EDGE_W   = $clog2(PRE_EDGES + 1),
  localparam int CNT_W    = $clog2(CODE_W + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [PORTS-1:0]                  lineIn,
  input  logic [HANDLERS-1:0]               handlerBusy,
  input  dpStrobe_t                         strobe,
  output logic [PORTS-1:0]                  toggle,
  output logic [PORTS-1:0][EDGE_W-1:0]      edgeCnt,
  output logic [PORTS-1:0][CNT_W-1:0]       codeCnt,
  output logic [PORTS-1:0][CODE_W-1:0]      codeWord,
  output logic [HANDLERS-1:0]               busyFall,
  output logic [HANDLERS-1:0][PSEL_W-1:0]   ringPtr
);

  logic [PORTS-1:0] linePrev;

  for (genvar p = 0; p < PORTS; p++) begin : gPort
    logic [CODE_W-2:0] shiftReg;

    assign toggle[p]   = lineIn[p] ^ linePrev[p];
    assign codeWord[p] = {shiftReg, lineIn[p]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        linePrev[p] <= 1'b0;
        edgeCnt[p]  <= '0;
        codeCnt[p]  <= '0;
        shiftReg    <= '0;
      end else begin
        linePrev[p] <= lineIn[p];
        if (strobe.edgeClr[p])      edgeCnt[p] <= '0;
        else if (strobe.edgeInc[p]) edgeCnt[p] <= edgeCnt[p] + EDGE_W'(1);
        if (strobe.codeClr[p]) begin
          codeCnt[p] <= '0;
        end else if (strobe.codeShift[p]) begin
          codeCnt[p] <= codeCnt[p] + CNT_W'(1);
          shiftReg   <= codeWord[p][CODE_W-2:0];
        end
      end
    end
  end

  for (genvar h = 0; h < HANDLERS; h++) begin : gHandler
    logic busyPrev;

    assign busyFall[h] = busyPrev & ~handlerBusy[h];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busyPrev   <= 1'b0;
        ringPtr[h] <= '0;
      end else begin
        busyPrev <= handlerBusy[h];
        if (strobe.ptrStep[h]) begin
          if (ringPtr[h] == PSEL_W'(PORTS - 1)) ringPtr[h] <= '0;
          else                                  ringPtr[h] <= ringPtr[h] + PSEL_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/line_req_control.sv
module line_req_control
  import line_req_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int PRE_EDGES = 2,
  parameter logic [CODE_W-1:0] CODE_NN  = 4'b1010,
  parameter logic [CODE_W-1:0] CODE_ND  = 4'b1100,
  parameter logic [CODE_W-1:0] CODE_TRQ = 4'b1001,
  localparam int EDGE_W   = $clog2(PRE_EDGES + 1),
  localparam int CNT_W    = $clog2(CODE_W + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [PORTS-1:0]                  lineBusy,
  input  logic [HANDLERS-1:0]               handlerBusy,
  input  logic [PORTS-1:0]                  toggle,
  input  logic [PORTS-1:0][EDGE_W-1:0]      edgeCnt,
  input  logic [PORTS-1:0][CNT_W-1:0]       codeCnt,
  input  logic [PORTS-1:0][CODE_W-1:0]      codeWord,
  input  logic [HANDLERS-1:0]               busyFall,
  input  logic [HANDLERS-1:0][PSEL_W-1:0]   ringPtr,
  output dpStrobe_t                         strobe,
  output logic                              wake,
  output logic [PORTS-1:0][TYPE_W-1:0]      kindOut,
  output logic [HANDLERS-1:0]               ownerValid,
  output logic [HANDLERS-1:0][PSEL_W-1:0]   owner
);

  portState_t                       state     [PORTS];
  portState_t                       stateNext [PORTS];
  logic [PORTS-1:0][TYPE_W-1:0]     kindReg, kindNext;
  logic [HANDLERS-1:0][PORTS-1:0]   reqVec;
  logic [HANDLERS-1:0]              grantFire;
  logic [HANDLERS-1:0][PSEL_W-1:0]  winIdx;
  logic [PORTS-1:0]                 winMask, loseMask, relMask;

  // per-handler rotating choice among waiting ports
  always_comb begin : arbComb
    logic found;
    int   idx;
    reqVec   = '0;
    winIdx   = '0;
    winMask  = '0;
    loseMask = '0;
    relMask  = '0;
    for (int h = 0; h < HANDLERS; h++) begin
      for (int p = 0; p < PORTS; p++) begin
        reqVec[h][p] = (state[p] == ST_WAIT) && (kindReg[p] == TYPE_W'(h + 1));
      end
      grantFire[h] = !ownerValid[h] && !handlerBusy[h] && (|reqVec[h]);
      found = 1'b0;
      for (int k = 0; k < PORTS; k++) begin
        idx = (int'(ringPtr[h]) + k) % PORTS;
        if (!found && reqVec[h][idx]) begin
          found     = 1'b1;
          winIdx[h] = PSEL_W'(idx);
        end
      end
      for (int p = 0; p < PORTS; p++) begin
        if (grantFire[h] && reqVec[h][p]) begin
          if (winIdx[h] == PSEL_W'(p)) winMask[p]  = 1'b1;
          else                         loseMask[p] = 1'b1;
        end
      end
      if (ownerValid[h] && busyFall[h]) relMask[owner[h]] = 1'b1;
    end
  end

  // per-port detector sequencing
  always_comb begin
    strobe         = '0;
    strobe.ptrStep = grantFire;
    kindNext       = kindReg;
    for (int p = 0; p < PORTS; p++) begin
      stateNext[p] = state[p];
      case (state[p])
        ST_IDLE: begin
          if (!lineBusy[p] && toggle[p]) begin
            strobe.edgeInc[p] = 1'b1;
            stateNext[p]      = ST_PRE;
          end else begin
            strobe.edgeClr[p] = 1'b1;
          end
        end
        ST_PRE: begin
          if (lineBusy[p] || !toggle[p]) begin
            strobe.edgeClr[p] = 1'b1;
            stateNext[p]      = ST_IDLE;
          end else if (edgeCnt[p] == EDGE_W'(PRE_EDGES - 1)) begin
            strobe.edgeClr[p] = 1'b1;
            strobe.codeClr[p] = 1'b1;
            stateNext[p]      = ST_CODE;
          end else begin
            strobe.edgeInc[p] = 1'b1;
          end
        end
        ST_CODE: begin
          if (lineBusy[p]) begin
            stateNext[p] = ST_IDLE;
          end else begin
            strobe.codeShift[p] = 1'b1;
            if (codeCnt[p] == CNT_W'(CODE_W - 1)) begin
              stateNext[p] = ST_WAIT;
              if (codeWord[p] == CODE_NN)       kindNext[p] = TYPE_W'(1);
              else if (codeWord[p] == CODE_ND)  kindNext[p] = TYPE_W'(2);
              else if (codeWord[p] == CODE_TRQ) kindNext[p] = TYPE_W'(3);
              else                              stateNext[p] = ST_IDLE;
            end
          end
        end
        ST_WAIT: begin
          if (winMask[p]) begin
            stateNext[p] = ST_ACTIVE;
          end else if (loseMask[p]) begin
            stateNext[p] = ST_IDLE;
            kindNext[p]  = KIND_NONE;
          end
        end
        ST_ACTIVE: begin
          if (relMask[p]) begin
            stateNext[p] = ST_IDLE;
            kindNext[p]  = KIND_NONE;
          end
        end
        default: begin
          stateNext[p] = ST_IDLE;
          kindNext[p]  = KIND_NONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < PORTS; p++) state[p] <= ST_IDLE;
      kindReg    <= '0;
      ownerValid <= '0;
      owner      <= '0;
    end else begin
      for (int p = 0; p < PORTS; p++) state[p] <= stateNext[p];
      kindReg <= kindNext;
      for (int h = 0; h < HANDLERS; h++) begin
        if (grantFire[h]) begin
          ownerValid[h] <= 1'b1;
          owner[h]      <= winIdx[h];
        end else if (ownerValid[h] && busyFall[h]) begin
          ownerValid[h] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    wake = 1'b0;
    for (int p = 0; p < PORTS; p++) begin
      if (state[p] == ST_CODE || state[p] == ST_WAIT || state[p] == ST_ACTIVE) wake = 1'b1;
    end
  end

  assign kindOut = kindReg;

endmodule

// File: rtl/line_req_dispatch.sv
module line_req_dispatch
  import line_req_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int PRE_EDGES = 2,
  parameter logic [CODE_W-1:0] CODE_NN  = 4'b1010,
  parameter logic [CODE_W-1:0] CODE_ND  = 4'b1100,
  parameter logic [CODE_W-1:0] CODE_TRQ = 4'b1001,
  localparam int EDGE_W   = $clog2(PRE_EDGES + 1),
  localparam int CNT_W    = $clog2(CODE_W + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PORTS-1:0]              lineIn,
  input  logic [PORTS-1:0]              lineBusy,
  input  logic [HANDLERS-1:0]           handlerBusy,
  output logic                          wake,
  output logic [PORTS*TYPE_W-1:0]       reqType,
  output logic [HANDLERS-1:0]           handlerEn,
  output logic [HANDLERS*PSEL_W-1:0]    portSel
);

  dpStrobe_t                        strobe;
  logic [PORTS-1:0]                 toggle;
  logic [PORTS-1:0][EDGE_W-1:0]     edgeCnt;
  logic [PORTS-1:0][CNT_W-1:0]      codeCnt;
  logic [PORTS-1:0][CODE_W-1:0]     codeWord;
  logic [HANDLERS-1:0]              busyFall;
  logic [HANDLERS-1:0][PSEL_W-1:0]  ringPtr;
  logic [PORTS-1:0][TYPE_W-1:0]     kindOut;
  logic [HANDLERS-1:0][PSEL_W-1:0]  owner;

  line_req_datapath #(
    .CODE_W    (CODE_W),
    .PRE_EDGES (PRE_EDGES)
  ) dp (
    .clk         (clk),
    .rstN        (rstN),
    .lineIn      (lineIn),
    .handlerBusy (handlerBusy),
    .strobe      (strobe),
    .toggle      (toggle),
    .edgeCnt     (edgeCnt),
    .codeCnt     (codeCnt),
    .codeWord    (codeWord),
    .busyFall    (busyFall),
    .ringPtr     (ringPtr)
  );

  line_req_control #(
    .CODE_W    (CODE_W),
    .PRE_EDGES (PRE_EDGES),
    .CODE_NN   (CODE_NN),
    .CODE_ND   (CODE_ND),
    .CODE_TRQ  (CODE_TRQ)
  ) ctl (
    .clk         (clk),
    .rstN        (rstN),
    .lineBusy    (lineBusy),
    .handlerBusy (handlerBusy),
    .toggle      (toggle),
    .edgeCnt     (edgeCnt),
    .codeCnt     (codeCnt),
    .codeWord    (codeWord),
    .busyFall    (busyFall),
    .ringPtr     (ringPtr),
    .strobe      (strobe),
    .wake        (wake),
    .kindOut     (kindOut),
    .ownerValid  (handlerEn),
    .owner       (owner)
  );

  assign reqType = kindOut;
  assign portSel = owner;

endmodule

// File: rtl/line_req_dispatch_chk.sv
module line_req_dispatch_chk
  import line_req_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          wake,
  input logic [PORTS*TYPE_W-1:0]       reqType,
  input logic [HANDLERS-1:0]           handlerEn,
  input logic [HANDLERS-1:0]           handlerBusy,
  input logic [HANDLERS*PSEL_W-1:0]    portSel
);

  for (genvar p = 0; p < PORTS; p++) begin : gPortChk
    // R4
    wake_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
      (reqType[p*TYPE_W +: TYPE_W] != '0) |-> wake);
  end

  for (genvar h = 0; h < HANDLERS; h++) begin : gHandlerChk
    logic [TYPE_W-1:0] selKind;
    assign selKind = reqType[int'(portSel[h*PSEL_W +: PSEL_W])*TYPE_W +: TYPE_W];

    // R6
    grant_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
      handlerEn[h] |-> (selKind == TYPE_W'(h + 1)));

    // R7
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(handlerEn[h]) |-> !$past(handlerBusy[h]));

    // R9
    release_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(handlerEn[h]) |-> ($past(handlerBusy[h], 2) && !$past(handlerBusy[h])));

    // R11
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (handlerEn[h] && $past(handlerEn[h])) |-> $stable(portSel[h*PSEL_W +: PSEL_W]));
  end

endmodule

bind line_req_dispatch line_req_dispatch_chk chk (.*);

// File: tb/line_req_dispatch_test.sv
module line_req_dispatch_test;
  import line_req_pkg::*;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic                       clk = 1'b0;
  logic                       rstN;
  logic [PORTS-1:0]           lineIn;
  logic [PORTS-1:0]           lineBusy;
  logic [HANDLERS-1:0]        handlerBusy;
  logic                       wake;
  logic [PORTS*TYPE_W-1:0]    reqType;
  logic [HANDLERS-1:0]        handlerEn;
  logic [HANDLERS*PSEL_W-1:0] portSel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int ptrModel [HANDLERS];

  always #(CLK_PERIOD/2) clk = ~clk;

  line_req_dispatch uut (
    .clk         (clk),
    .rstN        (rstN),
    .lineIn      (lineIn),
    .lineBusy    (lineBusy),
    .handlerBusy (handlerBusy),
    .wake        (wake),
    .reqType     (reqType),
    .handlerEn   (handlerEn),
    .portSel     (portSel)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int kindOf(input logic [3:0] code);
    case (code)
      4'b1010: return 1;
      4'b1100: return 2;
      4'b1001: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int rt(input int p);
    return int'(reqType[p*TYPE_W +: TYPE_W]);
  endfunction

  function automatic int ps(input int h);
    return int'(portSel[h*PSEL_W +: PSEL_W]);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // preamble 1,0 then code MSB first on each masked port; returns at the
  // negedge after the last code bit was sampled, with masked lines back low
  task automatic sendFrames(input logic [15:0] codes, input logic [3:0] mask);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      for (int p = 0; p < PORTS; p++) begin
        if (mask[p]) begin
          if (c == 0)      lineIn[p] = 1'b1;
          else if (c == 1) lineIn[p] = 1'b0;
          else             lineIn[p] = codes[4*p + 5 - c];
        end
      end
    end
    @(negedge clk);
    lineIn = lineIn & ~mask;
  endtask

  task automatic expectGrant(input string req, input int h, input int p);
    check(req, $sformatf("handlerEn[%0d]", h), int'(handlerEn[h]), 1);
    check(req, $sformatf("portSel[%0d]", h), ps(h), p);
    ptrModel[h] = (ptrModel[h] + 1) % PORTS;
  endtask

  // handler h raises busy, holds it, drops it; port p must be released
  task automatic finish(input int h, input int p);
    @(negedge clk);
    handlerBusy[h] = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R9", $sformatf("reqType[%0d] held", p), rt(p), h + 1);
      check("R11", $sformatf("portSel[%0d] held", h), ps(h), p);
    end
    handlerBusy[h] = 1'b0;
    @(negedge clk);
    check("R9", $sformatf("handlerEn[%0d] cleared", h), int'(handlerEn[h]), 0);
    check("R9", $sformatf("reqType[%0d] cleared", p), rt(p), 0);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int h = 0; h < HANDLERS; h++) ptrModel[h] = 0;
    rstN        = 1'b0;
    lineIn      = '0;
    lineBusy    = '0;
    handlerBusy = '0;
    idle(3);
    // R1 reset state
    check("R1", "wake", int'(wake), 0);
    check("R1", "handlerEn", int'(handlerEn), 0);
    check("R1", "reqType", int'(reqType), 0);
    rstN = 1'b1;
    idle(2);

    // R3 / R4 / R6 / R9: every code on every port
    for (int p = 0; p < PORTS; p++) begin
      for (int code = 0; code < 16; code++) begin
        logic [15:0] v;
        int k;
        v = 16'(code) << (4*p);
        k = kindOf(4'(code));
        sendFrames(v, 4'(1 << p));
        check("R3", $sformatf("reqType[%0d] code %0d", p, code), rt(p), k);
        check("R4", $sformatf("wake code %0d", code), int'(wake), (k != 0) ? 1 : 0);
        if (k != 0) begin
          @(negedge clk);
          expectGrant("R6", k - 1, p);
          finish(k - 1, p);
          check("R4", "wake after release", int'(wake), 0);
        end
        idle(3);
      end
    end

    // R2 lone transition never wakes
    @(negedge clk); lineIn[1] = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R2", "wake after single transition", int'(wake), 0);
    end
    lineIn[1] = 1'b0;
    idle(3);
    check("R2", "wake after return low", int'(wake), 0);

    // R2 wake timing
    @(negedge clk); lineIn[3] = 1'b1;
    @(negedge clk); check("R2", "wake after first transition", int'(wake), 0);
    lineIn[3] = 1'b0;
    @(negedge clk); check("R2", "wake after second transition", int'(wake), 1);
    for (int c = 0; c < 4; c++) begin
      lineIn[3] = 1'b0;
      @(negedge clk);
    end
    check("R3", "invalid code 0000 returns idle", int'(wake), 0);
    idle(3);

    // R5 whole frame while occupied
    lineBusy[2] = 1'b1;
    sendFrames(16'hA00, 4'b0100);
    check("R5", "reqType[2] under lineBusy", rt(2), 0);
    check("R5", "wake under lineBusy", int'(wake), 0);
    lineBusy[2] = 1'b0;
    idle(3);

    // R5 occupied mid-code
    @(negedge clk); lineIn[2] = 1'b1;
    @(negedge clk); lineIn[2] = 1'b0;
    @(negedge clk); lineIn[2] = 1'b1; lineBusy[2] = 1'b1;
    @(negedge clk); lineIn[2] = 1'b0;
    check("R5", "wake after mid-frame abort", int'(wake), 0);
    @(negedge clk); lineIn[2] = 1'b1;
    @(negedge clk); lineIn[2] = 1'b0;
    @(negedge clk);
    check("R5", "reqType[2] after abort", rt(2), 0);
    lineBusy[2] = 1'b0;
    idle(3);

    // R6 three handlers to three ports in the same cycle
    sendFrames(16'h0C9A, 4'hF);
    check("R3", "reqType[0] concurrent", rt(0), 1);
    check("R3", "reqType[1] concurrent", rt(1), 3);
    check("R3", "reqType[2] concurrent", rt(2), 2);
    check("R3", "reqType[3] concurrent", rt(3), 0);
    @(negedge clk);
    expectGrant("R6", 0, 0);
    expectGrant("R6", 1, 2);
    expectGrant("R6", 2, 1);
    finish(2, 1);
    check("R9", "reqType[0] untouched by other release", rt(0), 1);
    check("R9", "reqType[2] untouched by other release", rt(2), 2);
    finish(0, 0);
    finish(1, 2);
    idle(2);

    // R7 handler busy without owner defers the grant
    @(negedge clk); handlerBusy[1] = 1'b1;
    sendFrames(16'hC000, 4'b1000);
    check("R7", "reqType[3] waiting", rt(3), 2);
    idle(2);
    check("R7", "handlerEn[1] held off", int'(handlerEn[1]), 0);
    check("R7", "reqType[3] still waiting", rt(3), 2);
    handlerBusy[1] = 1'b0;
    @(negedge clk);
    expectGrant("R7", 1, 3);
    finish(1, 3);
    idle(2);

    // R8 four ports contend for the packet receiver
    for (int round = 0; round < 5; round++) begin
      int win;
      sendFrames(16'hAAAA, 4'hF);
      win = ptrModel[0];
      @(negedge clk);
      expectGrant("R8", 0, win);
      for (int p = 0; p < PORTS; p++) begin
        check("R8", $sformatf("round %0d reqType[%0d]", round, p), rt(p), (p == win) ? 1 : 0);
      end
      finish(0, win);
      idle(2);
    end

    // R10 frame on a served port is ignored
    sendFrames(16'h000A, 4'b0001);
    @(negedge clk);
    expectGrant("R6", 0, 0);
    sendFrames(16'h000C, 4'b0001);
    @(negedge clk);
    check("R10", "reqType[0] unchanged", rt(0), 1);
    check("R10", "handlerEn[1] stays low", int'(handlerEn[1]), 0);
    check("R10", "handlerEn[0] stays high", int'(handlerEn[0]), 1);
    finish(0, 0);
    idle(3);
    check("R10", "no request left behind", int'(reqType), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule